// File: doc/BRIEF.md
# Video activity overflow counter

This block measures how long graphics activity keeps the graphics speedup timer busy. Every time that speedup timer is triggered, the block opens a measurement window that runs for a fixed number of 1 ms ticks (100 by default). If the window runs to its end while the speedup timer still reports that it is running, a 16-bit overflow count goes up by one and a fresh window begins at once. If the speedup timer runs out first, the window closes quietly and nothing is counted.

Software reads the count to judge whether graphics work is sustained or bursty. It clears the count with a strobe before a new evaluation period and may also load a value directly. The count saturates at its maximum instead of wrapping. The bus interface that carries the reads and writes lies outside this block.

Top module: `vid_ovf_monitor`

## Requirements
- R1: After reset the count reads 0000h and no window is open, so ticks alone cause no increment.
- R2: A cycle with `trig_i` high opens the window with its tick count at zero, or restarts an open window from zero; a tick in that same cycle is not counted.
- R3: While the window is open and `busy_i` stays high, the 100th tick counted since the window opened raises the count by one, and the new value is visible on the clock edge that ends that tick's cycle.
- R4: On an overflow the window restarts at once, so a speedup timer that stays busy produces one increment every 100 ticks with no trigger in between.
- R5: A cycle with the window open, `busy_i` low and no trigger closes the window without incrementing. Ticks that arrive while the window is closed have no effect, even if `busy_i` goes high again without a trigger.
- R6: The count saturates at FFFFh; an overflow at FFFFh leaves it at FFFFh.
- R7: `clr_i` sets the count to 0000h on the next edge and takes priority over a write and over an increment in the same cycle.
- R8: `wr_en_i` loads `wr_data_i` into the count on the next edge and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle pulse every 1 ms |
| trig_i | input | 1 | One-cycle pulse when the graphics speedup timer is (re)loaded |
| busy_i | input | 1 | High while the graphics speedup timer is running |
| clr_i | input | 1 | Software clear strobe for the count |
| wr_en_i | input | 1 | Software write strobe for the count |
| wr_data_i | input | 16 | Value loaded by a write |
| count_o | output | 16 | Current overflow count |

## Verification
A wrong window tick count shows at `count_o` as an increment that arrives one or more ticks early or late, so the bench probes both the 99th and the 100th tick after a trigger and after a retrigger. A window that fails to close on a lapse, or fails to reopen after an overflow, shows as an extra or missing increment within the next 100 ticks. Priority mistakes among clear, write and increment show on the very next edge, so the bench aligns each strobe with the expiring tick.

// File: rtl/vom_pkg.sv
package vom_pkg;

    localparam int unsigned CNT_W_DEF     = 16;
    localparam int unsigned WIN_TICKS_DEF = 100;

    // Source of the next count value, in priority order
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_CLEAR = 2'd1,
        UPD_LOAD  = 2'd2,
        UPD_INC   = 2'd3
    } upd_sel_e;

endpackage

// File: rtl/vom_window.sv
module vom_window #(
    parameter int unsigned WIN_TICKS = vom_pkg::WIN_TICKS_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_ms_i,
    input  logic trig_i,
    input  logic busy_i,
    output logic active_o,
    output logic expire_o
);

    localparam int unsigned WIN_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
    localparam logic [WIN_W-1:0] LAST_TICK = WIN_W'(WIN_TICKS - 1);

    typedef struct packed {
        logic             active;
        logic [WIN_W-1:0] ticks;
    } win_state_t;

    win_state_t st_d, st_q;
    logic       expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;
        if (trig_i) begin
            // open or restart the window from zero
            st_d.active = 1'b1;
            st_d.ticks  = '0;
        end else if (st_q.active && !busy_i) begin
            // speedup timer lapsed first: close silently
            st_d.active = 1'b0;
            st_d.ticks  = '0;
        end else if (st_q.active && tick_ms_i) begin
            if (st_q.ticks == LAST_TICK) begin
                expire_d   = 1'b1;
                st_d.ticks = '0;
            end else begin
                st_d.ticks = st_q.ticks + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign expire_o = expire_d;

endmodule

// File: rtl/vom_counter.sv
module vom_counter #(
    parameter int unsigned CNT_W = vom_pkg::CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             clr_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o
);

    import vom_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    upd_sel_e   sel;

    always_comb begin
        if (clr_i) begin
            sel = UPD_CLEAR;
        end else if (wr_en_i) begin
            sel = UPD_LOAD;
        end else if (inc_i && (st_q.count != CNT_MAX)) begin
            sel = UPD_INC;
        end else begin
            sel = UPD_HOLD;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (sel)
            UPD_CLEAR: st_d.count = '0;
            UPD_LOAD:  st_d.count = wr_data_i;
            UPD_INC:   st_d.count = st_q.count + 1'b1;
            default:   st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

endmodule

// File: rtl/vid_ovf_monitor.sv
module vid_ovf_monitor #(
    parameter int unsigned CNT_W     = vom_pkg::CNT_W_DEF,
    parameter int unsigned WIN_TICKS = vom_pkg::WIN_TICKS_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_ms_i,
    input  logic             trig_i,
    input  logic             busy_i,
    input  logic             clr_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o
);

    logic win_active;
    logic win_expire;

    vom_window #(
        .WIN_TICKS(WIN_TICKS)
    ) i_window (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_ms_i(tick_ms_i),
        .trig_i   (trig_i),
        .busy_i   (busy_i),
        .active_o (win_active),
        .expire_o (win_expire)
    );

    vom_counter #(
        .CNT_W(CNT_W)
    ) i_counter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .inc_i    (win_expire),
        .clr_i    (clr_i),
        .wr_en_i  (wr_en_i),
        .wr_data_i(wr_data_i),
        .count_o  (count_o)
    );

endmodule

// File: rtl/vom_checker.sv
module vom_checker #(
    parameter int unsigned CNT_W = vom_pkg::CNT_W_DEF
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             trig_i,
    input logic             clr_i,
    input logic             wr_en_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic [CNT_W-1:0] count_o,
    input logic             win_active,
    input logic             win_expire
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_trig_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_i |=> win_active);

    assert_expire_steps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_expire && !clr_i && !wr_en_i && count_o != CNT_MAX)
            |=> count_o == $past(count_o) + 1'b1);

    assert_closed_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!win_active && !clr_i && !wr_en_i) |=> $stable(count_o));

    assert_saturate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == CNT_MAX && !clr_i && !wr_en_i) |=> count_o == CNT_MAX);

    assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> count_o == '0);

    assert_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !clr_i) |=> count_o == $past(wr_data_i));

endmodule

bind vid_ovf_monitor vom_checker #(
    .CNT_W(CNT_W)
) i_vom_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .clr_i     (clr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .count_o   (count_o),
    .win_active(win_active),
    .win_expire(win_expire)
);

// File: tb/test_vid_ovf_monitor.sv
module test_vid_ovf_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        trig = 1'b0;
    logic        busy = 1'b0;
    logic        clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] exp_cnt = '0;

    always #5ns clk = ~clk;

    vid_ovf_monitor i_vid_ovf_monitor (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .tick_ms_i(tick),
        .trig_i   (trig),
        .busy_i   (busy),
        .clr_i    (clr),
        .wr_en_i  (wr_en),
        .wr_data_i(wr_data),
        .count_o  (count)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic trigger();
        @(negedge clk) begin trig = 1'b1; busy = 1'b1; end
        @(negedge clk) trig = 1'b0;
    endtask

    // close any window and zero the count
    task automatic settle();
        @(negedge clk) begin busy = 1'b0; clr = 1'b1; end
        @(negedge clk) clr = 1'b0;
        exp_cnt = '0;
    endtask

    task automatic t_reset();
        check("R1 reset count", count, 16'h0000);
        busy = 1'b1;
        ticks(120);
        check("R1 no window after reset", count, 16'h0000);
        busy = 1'b0;
    endtask

    task automatic t_single();
        settle();
        trigger();
        ticks(99);
        check("R3 99th tick no increment", count, 16'h0000);
        ticks(1);
        check("R3 100th tick increments", count, 16'h0001);
    endtask

    task automatic t_sustained();
        settle();
        trigger();
        ticks(250);
        check("R4 sustained 250 ticks", count, 16'h0002);
        ticks(50);
        check("R4 sustained 300 ticks", count, 16'h0003);
    endtask

    task automatic t_lapse();
        settle();
        trigger();
        ticks(50);
        @(negedge clk) busy = 1'b0;
        @(negedge clk);
        ticks(150);
        check("R5 lapse no increment", count, 16'h0000);
        @(negedge clk) busy = 1'b1;
        ticks(120);
        check("R5 busy without trigger ignored", count, 16'h0000);
        trigger();
        ticks(100);
        check("R5 reopen after lapse", count, 16'h0001);
    endtask

    task automatic t_retrigger();
        settle();
        trigger();
        ticks(60);
        trigger();
        ticks(60);
        check("R2 retrigger restarts window", count, 16'h0000);
        ticks(39);
        check("R2 99 ticks after retrigger", count, 16'h0000);
        ticks(1);
        check("R2 100 ticks after retrigger", count, 16'h0001);
        // trigger coinciding with a tick: that tick is dropped
        settle();
        trigger();
        ticks(99);
        @(negedge clk) begin trig = 1'b1; tick = 1'b1; end
        @(negedge clk) begin trig = 1'b0; tick = 1'b0; end
        check("R2 trigger beats tick", count, 16'h0000);
        ticks(99);
        check("R2 tick in trigger cycle not counted", count, 16'h0000);
        ticks(1);
        check("R2 full window after trigger+tick", count, 16'h0001);
    endtask

    task automatic t_saturate();
        settle();
        @(negedge clk) begin wr_en = 1'b1; wr_data = 16'hFFFE; end
        @(negedge clk) wr_en = 1'b0;
        check("R8 write loads", count, 16'hFFFE);
        trigger();
        ticks(100);
        check("R6 reach max", count, 16'hFFFF);
        ticks(100);
        check("R6 saturate at max", count, 16'hFFFF);
    endtask

    task automatic t_priority();
        // clear coinciding with the expiring tick
        settle();
        @(negedge clk) begin wr_en = 1'b1; wr_data = 16'h0010; end
        @(negedge clk) wr_en = 1'b0;
        trigger();
        ticks(99);
        @(negedge clk) begin tick = 1'b1; clr = 1'b1; wr_en = 1'b1; wr_data = 16'h1234; end
        @(negedge clk) begin tick = 1'b0; clr = 1'b0; wr_en = 1'b0; end
        check("R7 clear beats write and increment", count, 16'h0000);
        ticks(100);
        check("R4 window restarted after cleared overflow", count, 16'h0001);
        // write coinciding with the expiring tick
        ticks(99);
        @(negedge clk) begin tick = 1'b1; wr_en = 1'b1; wr_data = 16'h0ABC; end
        @(negedge clk) begin tick = 1'b0; wr_en = 1'b0; end
        check("R8 write beats increment", count, 16'h0ABC);
        ticks(100);
        check("R8 count resumes after write", count, 16'h0ABD);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        check("R7 plain clear", count, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_sustained();
        t_lapse();
        t_retrigger();
        t_saturate();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule